// File: doc/BRIEF.md
# Video Pixel Checksum Accumulator

This block folds one colour component of the outgoing pixel stream into a running 24-bit signature, sampled on every pixel clock at the last point before the digital-to-analog converter inputs. Software picks red, green or blue, enables capture, and then waits for the done flag. It reads the signature of a whole frame and compares it with a value predicted from the image in software, or with the value a known-good unit produced for the same picture.

Only cycles flagged as active (unblanked) video contribute. Blanking cycles of any length, their data and any extra sync cycles leave the signature untouched, so two identical images give identical results whatever the video timing. Each contributing pixel rotates the register left by one bit before its component is folded in. A swapped pair of pixels therefore changes the result. Frame boundaries come from a frame-start pulse: the first pulse seen with capture enabled opens a frame, and every later pulse closes the current frame into the result register and opens the next.

Top module: `pixel_checksum`

## Requirements
- R1: After a clock edge with `rst_n` low, `sum_out` reads 0 and `sum_done` reads 0.
- R2: The channel code on `chan_sel` selects the component: 0 is red, 1 is green, 2 is blue, and the unused code 3 also selects blue.
- R3: For each contributing pixel, the accumulator becomes its previous value rotated left by one bit (bit 23 wraps into bit 0), XORed with the selected 8-bit component placed in bits 7:0.
- R4: A cycle with `pix_active` low leaves the accumulator unchanged whatever the pixel data, so the same image with different blanking lengths yields the same checksum.
- R5: A frame-start cycle with `cap_en` high clears the accumulator before that cycle's pixel is taken, and that pixel counts as the first of the new frame when `pix_active` is high.
- R6: A frame-start cycle while a frame is open and `cap_en` is high copies the accumulated value, excluding that cycle's pixel, to `sum_out` and sets `sum_done`. `sum_out` changes at no other time.
- R7: `chan_sel` is sampled only on the frame-start cycle that opens a frame. A change during the frame takes effect from the next frame start.
- R8: Dropping `cap_en` while a frame is open abandons it. This also holds on a frame-start cycle. No capture takes place, and `sum_out` and `sum_done` keep their values.
- R9: Opening a frame from the idle state clears `sum_done` and leaves `sum_out` at its previous value.
- R10: Exchanging the first two pixels of an image whose components differ gives a different checksum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cap_en | input | 1 | Capture enable |
| chan_sel | input | 2 | Component select: 0 red, 1 green, 2 or 3 blue |
| pix_r | input | 8 | Red component at the converter input |
| pix_g | input | 8 | Green component at the converter input |
| pix_b | input | 8 | Blue component at the converter input |
| pix_active | input | 1 | High on unblanked pixels |
| frame_start | input | 1 | One-cycle pulse at the start of each frame |
| sum_out | output | 24 | Checksum of the last completed frame |
| sum_done | output | 1 | A frame checksum has been captured since the last fresh start |

## Verification
On every cycle the assertions check the following:
- an open frame closes when enable falls;
- the latched select holds between frame starts;
- `sum_done` rises only after a capture and falls after a fresh start;
- blank cycles leave the accumulator still;
- the result register moves only on a capture, and then to the accumulated value.

Only the bench scenarios can show that the arithmetic matches a checksum computed from the image: the channel mapping, the counting of a pixel on the frame-start cycle, equality under different blanking, and sensitivity to pixel order. These are checked against checksums computed from the image pixels in raster order.

// File: rtl/pxck_pkg.sv
// Shared constants and types for the pixel checksum block.
// Assumes exactly three colour components, indexed red, green, blue.
package pxck_pkg;
    localparam int PXCK_NUM_CH = 3;
    localparam int PXCK_SEL_W  = 2;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } pxck_state_e;
endpackage

// File: rtl/pxck_chan_mux.sv
// Component selector: picks one COMP_W-bit component out of NUM_CH packed
// components. Codes at or beyond the last index select the last component.
// Assumes NUM_CH >= 2 and that index 0 sits in the low bits of comps.
module pxck_chan_mux #(
    parameter int COMP_W = 8,
    parameter int NUM_CH = 3,
    parameter int SEL_W  = 2
) (
    input  logic [NUM_CH*COMP_W-1:0] comps,
    input  logic [SEL_W-1:0]         sel,
    output logic [COMP_W-1:0]        comp
);
    localparam int CMP_W = SEL_W + 1;

    logic [NUM_CH-1:0] hit;

    // Decode the code into one hit line per component; the last one absorbs spare codes.
    for (genvar gi = 0; gi < NUM_CH; gi++) begin : g_hit
        if (gi == NUM_CH - 1) begin : g_last
            assign hit[gi] = ({1'b0, sel} >= CMP_W'(gi));
        end else begin : g_mid
            assign hit[gi] = ({1'b0, sel} == CMP_W'(gi));
        end
    end

    // OR together the component picked by the hit line.
    always_comb begin
        comp = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (hit[i]) begin
                comp = comp | comps[i*COMP_W +: COMP_W];
            end
        end
    end
endmodule

// File: rtl/pxck_ctrl.sv
// Frame sequencer: tracks whether a frame is open, latches the channel code
// at each opening frame start, and flags captures and the done status.
// Assumes frame_start is a single-cycle pulse in the pixel clock domain.
module pxck_ctrl
    import pxck_pkg::*;
#(
    parameter int SEL_W = PXCK_SEL_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap_en,
    input  logic             frame_start,
    input  logic [SEL_W-1:0] chan_sel,
    output logic             open_frame,
    output logic             accum_ok,
    output logic             capture,
    output logic             done,
    output logic [SEL_W-1:0] sel_use
);
    pxck_state_e      st;
    logic [SEL_W-1:0] sel_lat;
    logic             fresh;
    logic             in_run;

    // Derive per-cycle strobes from the state and the inputs.
    always_comb begin
        in_run     = (st == ST_RUN);
        open_frame = cap_en && frame_start;
        capture    = open_frame && in_run;
        fresh      = open_frame && !in_run;
        accum_ok   = in_run && cap_en;
        sel_use    = open_frame ? chan_sel : sel_lat;
    end

    // Run/idle state: enable low always returns to idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= ST_IDLE;
        end else if (!cap_en) begin
            st <= ST_IDLE;
        end else if (frame_start) begin
            st <= ST_RUN;
        end
    end

    // Channel code held for the whole frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_lat <= '0;
        end else if (open_frame) begin
            sel_lat <= chan_sel;
        end
    end

    // Done flag: set by a capture, cleared by a fresh start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done <= 1'b0;
        end else if (capture) begin
            done <= 1'b1;
        end else if (fresh) begin
            done <= 1'b0;
        end
    end

    // R8
    abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_run && !cap_en) |=> (st == ST_IDLE));

    // R7
    sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_run && !frame_start) |=> $stable(sel_lat));

    // R6
    done_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(capture));

    // R9
    done_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fresh |=> !done);
endmodule

// File: rtl/pxck_accum.sv
// Signature register and result register. Each contributing pixel rotates
// the signature left by one and XORs in the component; a capture copies it out.
// Assumes ACC_W > COMP_W and that control strobes come from pxck_ctrl.
module pxck_accum #(
    parameter int COMP_W = 8,
    parameter int ACC_W  = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              open_frame,
    input  logic              accum_ok,
    input  logic              capture,
    input  logic              pix_active,
    input  logic [COMP_W-1:0] comp,
    output logic [ACC_W-1:0]  result
);
    logic [ACC_W-1:0] acc;
    logic [ACC_W-1:0] acc_nxt;

    function automatic logic [ACC_W-1:0] fold(input logic [ACC_W-1:0] a,
                                              input logic [COMP_W-1:0] c);
        return {a[ACC_W-2:0], a[ACC_W-1]} ^ ACC_W'(c);
    endfunction

    // Choose the next signature: restart, fold a pixel, or hold.
    always_comb begin
        if (open_frame) begin
            acc_nxt = pix_active ? fold('0, comp) : '0;
        end else if (accum_ok && pix_active) begin
            acc_nxt = fold(acc, comp);
        end else begin
            acc_nxt = acc;
        end
    end

    // Signature register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc <= '0;
        end else begin
            acc <= acc_nxt;
        end
    end

    // Result register, loaded only on a capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result <= '0;
        end else if (capture) begin
            result <= acc;
        end
    end

    // R4
    blank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accum_ok && !open_frame && !pix_active) |=> $stable(acc));

    // R6
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !capture |=> $stable(result));

    // R6
    result_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        capture |=> (result == $past(acc)));
endmodule

// File: rtl/pixel_checksum.sv
// Top of the pixel checksum block: selects one colour component of the
// stream at the converter inputs and signs each unblanked frame.
// Assumes all inputs are synchronous to the pixel clock.
module pixel_checksum
    import pxck_pkg::*;
#(
    parameter int COMP_W = 8,
    parameter int ACC_W  = 24
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cap_en,
    input  logic [PXCK_SEL_W-1:0] chan_sel,
    input  logic [COMP_W-1:0]     pix_r,
    input  logic [COMP_W-1:0]     pix_g,
    input  logic [COMP_W-1:0]     pix_b,
    input  logic                  pix_active,
    input  logic                  frame_start,
    output logic [ACC_W-1:0]      sum_out,
    output logic                  sum_done
);
    localparam int FLAT_W = PXCK_NUM_CH * COMP_W;

    logic [FLAT_W-1:0]     comps;
    logic [COMP_W-1:0]     comp;
    logic [PXCK_SEL_W-1:0] sel_use;
    logic                  open_frame;
    logic                  accum_ok;
    logic                  capture;

    assign comps = {pix_b, pix_g, pix_r};

    pxck_ctrl #(.SEL_W(PXCK_SEL_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .cap_en     (cap_en),
        .frame_start(frame_start),
        .chan_sel   (chan_sel),
        .open_frame (open_frame),
        .accum_ok   (accum_ok),
        .capture    (capture),
        .done       (sum_done),
        .sel_use    (sel_use)
    );

    pxck_chan_mux #(.COMP_W(COMP_W), .NUM_CH(PXCK_NUM_CH), .SEL_W(PXCK_SEL_W)) u_mux (
        .comps(comps),
        .sel  (sel_use),
        .comp (comp)
    );

    pxck_accum #(.COMP_W(COMP_W), .ACC_W(ACC_W)) u_accum (
        .clk       (clk),
        .rst_n     (rst_n),
        .open_frame(open_frame),
        .accum_ok  (accum_ok),
        .capture   (capture),
        .pix_active(pix_active),
        .comp      (comp),
        .result    (sum_out)
    );
endmodule

// File: tb/pixel_checksum_test.sv
`timescale 1ns/1ps
module pixel_checksum_test;
    localparam int W = 6;
    localparam int H = 4;
    localparam int N = W * H;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cap_en = 1'b0;
    logic [1:0]  chan_sel = 2'd0;
    logic [7:0]  pr = 8'd0, pg = 8'd0, pb = 8'd0;
    logic        act = 1'b0;
    logic        fs = 1'b0;
    logic [23:0] sum_out;
    logic        sum_done;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;
    int g_cyc, g_chg_at, g_chg_sel, g_abort_at;

    always #2 clk = ~clk;

    pixel_checksum uut (
        .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .chan_sel(chan_sel),
        .pix_r(pr), .pix_g(pg), .pix_b(pb), .pix_active(act),
        .frame_start(fs), .sum_out(sum_out), .sum_done(sum_done)
    );

    function automatic logic [7:0] pv(int id, bit sw, int k, int c);
        int kk;
        kk = (sw && k < 2) ? 1 - k : k;
        return 8'((id * 73 + kk * 29 + c * 151 + kk * kk * 7) ^ (id >> 3));
    endfunction

    // Expected checksum of an image, raster order (R2, R3).
    function automatic logic [23:0] csum(int id, bit sw, int sel);
        logic [23:0] a;
        int c;
        a = '0;
        c = (sel >= 2) ? 2 : sel;
        for (int k = 0; k < N; k++) begin
            a = {a[22:0], a[23]} ^ {16'h0, pv(id, sw, k, c)};
        end
        return a;
    endfunction

    task automatic chk(string tag, logic [23:0] got, logic [23:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic tick(bit f, bit a, logic [7:0] r, logic [7:0] g, logic [7:0] b);
        fs = f; act = a; pr = r; pg = g; pb = b;
        @(posedge clk);
        g_cyc++;
        if (g_cyc == g_chg_at) chan_sel = g_chg_sel[1:0];
        if (g_cyc == g_abort_at) cap_en = 1'b0;
        @(negedge clk);
    endtask

    task automatic blank_tick(bit f);
        tick(f, 1'b0, 8'($urandom), 8'($urandom), 8'($urandom));
    endtask

    task automatic frame(int id, bit sw, int vbl, int hb, bit fs_act,
                         int chg_at, int chg_sel, int abort_at);
        int k;
        k = 0;
        g_cyc = 0; g_chg_at = chg_at; g_chg_sel = chg_sel; g_abort_at = abort_at;
        if (fs_act) begin
            tick(1'b1, 1'b1, pv(id, sw, k, 0), pv(id, sw, k, 1), pv(id, sw, k, 2));
            k++;
        end else begin
            blank_tick(1'b1);
        end
        for (int v = 0; v < vbl * (W + hb); v++) blank_tick(1'b0);
        while (k < N) begin
            for (int x = 0; x < W; x++) begin
                if (k < N) begin
                    tick(1'b0, 1'b1, pv(id, sw, k, 0), pv(id, sw, k, 1), pv(id, sw, k, 2));
                    k++;
                end
            end
            for (int h = 0; h < hb; h++) blank_tick(1'b0);
        end
        g_chg_at = -1; g_abort_at = -1;
    endtask

    initial begin
        #(200000 * 4);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int prev_id, prev_sel, rid, rsel;
        void'($urandom(32'h5EED));
        g_chg_at = -1; g_abort_at = -1; g_cyc = 0;
        @(negedge clk);
        for (int i = 0; i < 4; i++) blank_tick(1'b0);
        chk("R1 reset sum", sum_out, 24'h0);
        chk("R1 reset done", {23'h0, sum_done}, 24'h1 & 24'h0);
        rst_n = 1'b1;

        cap_en = 1'b1; chan_sel = 2'd0;
        frame(1, 0, 2, 3, 0, 10, 1, -1);          // red, switched to green mid-frame
        chk("R6 no done before capture", {23'h0, sum_done}, 24'h0);
        frame(2, 0, 2, 3, 0, -1, 0, -1);          // green latched here
        chk("R7 mid-frame select ignored / R3 red sum", sum_out, csum(1, 0, 0));
        chk("R6 done after capture", {23'h0, sum_done}, 24'h1);
        frame(2, 0, 1, 6, 0, -1, 0, -1);          // same image, other blanking
        chk("R2 green sum", sum_out, csum(2, 0, 1));
        chan_sel = 2'd2;
        frame(4, 0, 0, 2, 1, -1, 0, -1);          // pixel on frame-start cycle
        chk("R4 blanking independence", sum_out, csum(2, 0, 1));
        chan_sel = 2'd3;
        frame(4, 1, 1, 4, 0, -1, 0, -1);          // swapped pair, code 3
        chk("R5 first pixel on frame start", sum_out, csum(4, 0, 2));
        frame(7, 0, 1, 3, 0, -1, 0, 20);          // aborted frame
        chk("R2 code 3 selects blue", sum_out, csum(4, 1, 2));
        n_chk++;
        if (sum_out === csum(4, 0, 2)) begin
            n_fail++;
            $display("FAIL R10 order sensitivity: actual=%h expected!=%h", sum_out, csum(4, 0, 2));
        end
        chk("R8 abort keeps done", {23'h0, sum_done}, 24'h1);
        chk("R8 abort keeps sum", sum_out, csum(4, 1, 2));

        cap_en = 1'b1; chan_sel = 2'd1;
        frame(8, 0, 1, 2, 0, -1, 0, -1);          // fresh start from idle
        chk("R9 done cleared on fresh start", {23'h0, sum_done}, 24'h0);
        chk("R9 sum held on fresh start", sum_out, csum(4, 1, 2));
        cap_en = 1'b0;
        blank_tick(1'b1);                          // frame start with enable low
        chk("R8 no capture with enable low", sum_out, csum(4, 1, 2));
        chk("R8 done unchanged", {23'h0, sum_done}, 24'h0);

        cap_en = 1'b1; chan_sel = 2'd0;
        frame(9, 0, 1, 2, 0, -1, 0, -1);
        prev_id = 9; prev_sel = 0;
        for (int i = 0; i < 5; i++) begin
            rid = $urandom_range(10, 200);
            rsel = $urandom_range(0, 3);
            chan_sel = rsel[1:0];
            frame(rid, 0, $urandom_range(0, 2), $urandom_range(1, 5),
                  1'($urandom_range(0, 1)), -1, 0, -1);
            chk("R3 random frame", sum_out, csum(prev_id, 0, prev_sel));
            prev_id = rid; prev_sel = rsel;
        end
        blank_tick(1'b1);
        chk("R6 final capture", sum_out, csum(prev_id, 0, prev_sel));

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule